// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is the transmit half of a UART channel. An 8-bit mode word picks the character length (7, 8 or 9 data bits), whether a parity bit is added and which sense it has, one or two stop bits, and where the bit clock comes from. The bit clock is the chosen source divided first by (n+1), where n is a reload value, and then by 16.

Software, or any upstream logic, drops a word into a one-entry holding buffer with a write strobe. When the shifter is idle, the transmit enable is high and the active-low clear-to-send input is low, the word moves into the shifter and a frame starts. The buffer is then free again, so the next word can wait there while the current frame is on the line. Two flags report separately whether the holding buffer is empty and whether the shifter is idle.

Top module: `sertx_top`

## Requirements
- R1: After a synchronous reset, and whenever the shifter is idle, `txd` is high. After reset, `buf_empty` and `shift_empty` are both 1.
- R2: `mode_cfg[2:0]` = 3'b100, 3'b101 or 3'b110 selects 7, 8 or 9 data bits, and `mode_cfg[7]` must be 0. Any other setting is invalid: no frame starts and a queued word stays in the buffer until the mode becomes valid.
- R3: A frame is a low start bit, then the data bits starting with bit 0, then the parity bit when `mode_cfg[6]`=1, then the high stop bit(s).
- R4: With `mode_cfg[5]`=1 the parity is even: the count of ones over data plus parity is even. With `mode_cfg[5]`=0 that count is odd.
- R5: `mode_cfg[4]`=0 gives one stop bit and `mode_cfg[4]`=1 gives two.
- R6: With `mode_cfg[3]`=0 every clock cycle is a source tick. Each bit lasts (reload+1)×16 ticks. A write into an empty buffer with an idle shifter drives the start bit on `txd` from the second clock edge after the strobe is sampled.
- R7: With `mode_cfg[3]`=1 only cycles with `ext_tick`=1 count as source ticks, so a tick on every other cycle doubles the bit time.
- R8: A word written while a frame is in progress waits in the buffer with `buf_empty`=0. Its frame starts on the clock edge after the previous frame's last stop bit ends.
- R9: While `tx_en` is 0 no frame starts. A frame already in progress runs to its end.
- R10: While `cts_n` is 1 no frame starts. Raising `cts_n` during a frame does not cut that frame short.
- R11: `buf_empty` goes to 0 on the edge that stores a write and returns to 1 on the edge that moves the word into the shifter. `shift_empty` is 0 from the start bit until the last stop bit has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 8 | Frame format and clock-source selection |
| reload | input | RLD_W | Bit-rate reload value n |
| ext_tick | input | 1 | External source tick, one cycle per tick |
| tx_en | input | 1 | Transmit enable; gates frame starts |
| cts_n | input | 1 | Active-low clear to send; gates frame starts |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to send; upper bits ignored in shorter modes |
| txd | output | 1 | Serial output line, idles high |
| buf_empty | output | 1 | Holding buffer is empty |
| shift_empty | output | 1 | Shifter is idle |

## Verification
The assertions watch properties that must hold on every cycle:
- the line stays high while the shifter is idle;
- every frame opens with a low bit;
- the line changes only on a bit tick;
- each start had a full buffer, a valid mode, enable high and clear-to-send low in the cycle before;
- the divider enters each frame with a cleared phase.

The exact bit pattern, the parity sense and the stop count can only be shown by the bench. It samples the middle of every bit against frames it builds itself. The same holds for bit time under both clock sources, for back-to-back frames through the buffer, and for a frame that runs on after enable or clear-to-send is withdrawn.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int MAX_DATA  = 9;
  localparam int FRAME_MAX = 1 + MAX_DATA + 1 + 2;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic             valid;
    logic [CNT_W-1:0] nbits;
    logic             par_en;
    logic             par_even;
    logic             two_stop;
    logic             ext_src;
  } fmt_t;

  function automatic fmt_t decode_mode(input logic [7:0] m);
    fmt_t f;
    f.valid = ~m[7];
    case (m[2:0])
      3'b100:  f.nbits = CNT_W'(7);
      3'b101:  f.nbits = CNT_W'(8);
      3'b110:  f.nbits = CNT_W'(9);
      default: begin
        f.nbits = CNT_W'(8);
        f.valid = 1'b0;
      end
    endcase
    f.ext_src  = m[3];
    f.two_stop = m[4];
    f.par_even = m[5];
    f.par_en   = m[6];
    return f;
  endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int RLD_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             src_tick,
  input  logic [RLD_W-1:0] reload,
  output logic             bit_tick
);
  localparam int OVS_W = $clog2(OVS);

  logic [RLD_W-1:0] pre_q;
  logic [OVS_W-1:0] ovs_q;
  logic             pre_wrap;
  logic             ovs_last;

  assign pre_wrap = run && src_tick && (pre_q == reload);
  assign ovs_last = (ovs_q == OVS_W'(OVS - 1));
  assign bit_tick = pre_wrap && ovs_last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      ovs_q <= '0;
    end else if (src_tick) begin
      if (pre_q == reload) begin
        pre_q <= '0;
        ovs_q <= ovs_last ? '0 : ovs_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R6: each frame starts its first bit time from a cleared divider phase
  a_r6_fresh_phase: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (pre_q == '0 && ovs_q == '0));

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
(
  input  fmt_t                 fmt,
  input  logic [MAX_DATA-1:0]  data,
  output logic [FRAME_MAX-1:0] frame,
  output logic [CNT_W-1:0]     nbits
);
  int   len;
  logic ones;
  logic pbit;

  always_comb begin
    len  = int'(fmt.nbits);
    ones = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < len) ones = ones ^ data[i];
    end
    pbit  = fmt.par_even ? ones : ~ones;
    frame = '1;
    frame[0] = 1'b0;
    for (int j = 1; j <= MAX_DATA; j++) begin
      if (j <= len) frame[j] = data[j-1];
    end
    for (int j = 1; j < FRAME_MAX; j++) begin
      if (fmt.par_en && (j == len + 1)) frame[j] = pbit;
    end
    nbits = CNT_W'(2) + fmt.nbits + CNT_W'(fmt.par_en) + CNT_W'(fmt.two_stop);
  end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [FRAME_MAX-1:0] frame,
  input  logic [CNT_W-1:0]     nbits,
  input  logic                 bit_tick,
  output logic                 txd,
  output logic                 busy
);
  logic [FRAME_MAX-1:0] sh_q;
  logic [CNT_W-1:0]     left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '1;
      left_q <= '0;
      busy   <= 1'b0;
      txd    <= 1'b1;
    end else if (start) begin
      sh_q   <= frame;
      left_q <= nbits;
      busy   <= 1'b1;
      txd    <= frame[0];
    end else if (busy && bit_tick) begin
      if (left_q == CNT_W'(1)) begin
        left_q <= '0;
        busy   <= 1'b0;
        txd    <= 1'b1;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
        txd    <= sh_q[1];
        left_q <= left_q - 1'b1;
      end
    end
  end

  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  a_r6_hold_line: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_tick) |=> $stable(txd));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    left_q <= CNT_W'(FRAME_MAX));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int RLD_W = 8,
  parameter int OVS   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          mode_cfg,
  input  logic [RLD_W-1:0]    reload,
  input  logic                ext_tick,
  input  logic                tx_en,
  input  logic                cts_n,
  input  logic                wr_stb,
  input  logic [MAX_DATA-1:0] wr_data,
  output logic                txd,
  output logic                buf_empty,
  output logic                shift_empty
);
  fmt_t                 fmt;
  logic [MAX_DATA-1:0]  buf_q;
  logic                 buf_full_q;
  logic                 busy;
  logic                 start;
  logic                 src_tick;
  logic                 bit_tick;
  logic [FRAME_MAX-1:0] frame;
  logic [CNT_W-1:0]     nbits;

  assign fmt      = decode_mode(mode_cfg);
  assign src_tick = fmt.ext_src ? ext_tick : 1'b1;
  assign start    = buf_full_q && !busy && tx_en && !cts_n && fmt.valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full_q <= 1'b0;
      buf_q      <= '0;
    end else if (wr_stb) begin
      buf_q      <= wr_data;
      buf_full_q <= 1'b1;
    end else if (start) begin
      buf_full_q <= 1'b0;
    end
  end

  assign buf_empty   = ~buf_full_q;
  assign shift_empty = ~busy;

  sertx_baud #(.RLD_W(RLD_W), .OVS(OVS)) u_baud (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .src_tick (src_tick),
    .reload   (reload),
    .bit_tick (bit_tick)
  );

  sertx_frame u_frame (
    .fmt   (fmt),
    .data  (buf_q),
    .frame (frame),
    .nbits (nbits)
  );

  sertx_shift u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .frame    (frame),
    .nbits    (nbits),
    .bit_tick (bit_tick),
    .txd      (txd),
    .busy     (busy)
  );

  logic mode_ok;
  assign mode_ok = !mode_cfg[7] &&
                   (mode_cfg[2:0] == 3'b100 || mode_cfg[2:0] == 3'b101 || mode_cfg[2:0] == 3'b110);

  // R9 and R10: a start needs enable high and clear-to-send low
  a_r9_start_gated: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_empty) |-> ($past(tx_en) && !$past(cts_n)));
  a_r2_valid_mode: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_empty) |-> $past(mode_ok));
  a_r8_needs_word: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_empty) |-> !$past(buf_empty));
  a_r11_buf_taken: assert property (@(posedge clk) disable iff (rst)
    ($fell(shift_empty) && !$past(wr_stb)) |-> buf_empty);

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mode_cfg = 8'h05;
  logic [7:0] reload = 8'd0;
  logic       ext_tick = 1'b0;
  logic       tx_en = 1'b1;
  logic       cts_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [8:0] wr_data = '0;
  logic       txd;
  logic       buf_empty;
  logic       shift_empty;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always @(negedge clk) ext_tick <= ~ext_tick;

  sertx_top u0 (
    .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .reload(reload),
    .ext_tick(ext_tick), .tx_en(tx_en), .cts_n(cts_n), .wr_stb(wr_stb),
    .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty)
  );

  // {mode[7:0], reload[3:0], data[8:0]}
  localparam logic [20:0] VEC [7] = '{
    {8'h05, 4'd0, 9'h0A5},
    {8'h65, 4'd1, 9'h037},
    {8'h45, 4'd0, 9'h037},
    {8'h14, 4'd2, 9'h05A},
    {8'h56, 4'd0, 9'h1C3},
    {8'h0D, 4'd0, 9'h081},
    {8'h76, 4'd0, 9'h100}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_frame(input logic [7:0] m, input logic [8:0] d,
                                   output logic [15:0] b);
    int   len;
    int   k;
    logic ones;
    len  = (m[2:0] == 3'b100) ? 7 : (m[2:0] == 3'b101) ? 8 : 9;
    b    = '1;
    b[0] = 1'b0;
    k    = 1;
    ones = 1'b0;
    for (int i = 0; i < len; i++) begin
      b[k] = d[i];
      ones = ones ^ d[i];
      k++;
    end
    if (m[6]) begin
      b[k] = m[5] ? ones : ~ones;
      k++;
    end
    k = k + (m[4] ? 2 : 1);
    return k;
  endfunction

  // Called at the negedge where the start bit has just appeared (offset 0), minus skip cycles
  task automatic expect_frame(input logic [7:0] m, input int rld, input logic [8:0] d,
                              input int skip, input string tag);
    logic [15:0] b;
    int total;
    int bc;
    bc    = (rld + 1) * 16 * (m[3] ? 2 : 1);
    total = exp_frame(m, d, b);
    repeat (bc / 2 - skip) @(negedge clk);
    chk({tag, " R3 start bit"}, txd, b[0]);
    for (int i = 1; i < total; i++) begin
      repeat (bc) @(negedge clk);
      chk({tag, " R3 R4 R5 frame bit"}, txd, b[i]);
    end
    repeat (bc - bc / 2 + (m[3] ? 2 : 0)) @(negedge clk);
    chk({tag, " R11 shifter idle after last stop"}, shift_empty, 1);
    chk({tag, " R1 line high after frame"}, txd, 1);
  endtask

  task automatic write_word(input logic [8:0] d);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset buf_empty", buf_empty, 1);
    chk("R1 reset shift_empty", shift_empty, 1);

    // Vector table: format, parity, stops, reload and clock source
    for (int v = 0; v < 7; v++) begin
      logic [7:0] m;
      logic [3:0] r;
      logic [8:0] d;
      {m, r, d} = VEC[v];
      mode_cfg = m;
      reload   = {4'd0, r};
      write_word(d);
      chk("R11 buffer holds word", buf_empty, 0);
      chk("R6 line still idle", txd, 1);
      @(negedge clk);
      chk("R6 start after load", txd, 0);
      chk("R11 buffer released", buf_empty, 1);
      chk("R11 shifter busy", shift_empty, 0);
      expect_frame(m, int'(r), d, 0, m[3] ? "R7 R2" : "R6 R2");
    end

    // Enable low holds off start
    mode_cfg = 8'h05;
    reload   = 8'd0;
    tx_en    = 1'b0;
    write_word(9'h03C);
    repeat (60) @(negedge clk);
    chk("R9 no start while disabled", txd, 1);
    chk("R9 shifter idle while disabled", shift_empty, 1);
    chk("R9 word kept", buf_empty, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R9 start after enable", txd, 0);
    tx_en = 1'b0;
    expect_frame(8'h05, 0, 9'h03C, 0, "R9 runs on after disable");
    tx_en = 1'b1;

    // Clear-to-send high holds off start
    cts_n = 1'b1;
    write_word(9'h0C3);
    repeat (60) @(negedge clk);
    chk("R10 no start while cts high", txd, 1);
    chk("R10 word kept", buf_empty, 0);
    cts_n = 1'b0;
    @(negedge clk);
    chk("R10 start after cts low", txd, 0);
    cts_n = 1'b1;
    expect_frame(8'h05, 0, 9'h0C3, 0, "R10 runs on after cts high");
    cts_n = 1'b0;

    // Invalid modes send nothing
    mode_cfg = 8'h07;
    write_word(9'h055);
    repeat (60) @(negedge clk);
    chk("R2 invalid mode no start", txd, 1);
    chk("R2 invalid mode word kept", buf_empty, 0);
    mode_cfg = 8'h85;
    repeat (40) @(negedge clk);
    chk("R2 reserved bit no start", shift_empty, 1);
    mode_cfg = 8'h05;
    @(negedge clk);
    chk("R2 start once valid", txd, 0);
    expect_frame(8'h05, 0, 9'h055, 0, "R2");

    // Double buffering: second word queued during first frame
    write_word(9'h0F0);
    @(negedge clk);
    chk("R8 first frame started", txd, 0);
    wr_stb  = 1'b1;
    wr_data = 9'h00F;
    @(negedge clk);
    wr_stb  = 1'b0;
    chk("R8 queued word shows full", buf_empty, 0);
    chk("R8 shifter busy with first", shift_empty, 0);
    expect_frame(8'h05, 0, 9'h0F0, 1, "R8 first");
    chk("R8 second still queued", buf_empty, 0);
    @(negedge clk);
    chk("R8 second starts next edge", txd, 0);
    chk("R8 buffer released", buf_empty, 1);
    expect_frame(8'h05, 0, 9'h00F, 0, "R8 second");

    // Reset in the middle of a frame
    write_word(9'h000);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-frame txd", txd, 1);
    chk("R1 reset mid-frame buf_empty", buf_empty, 1);
    chk("R1 reset mid-frame shift_empty", shift_empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule